// File: doc/BRIEF.md
# Interleaved Four-Thread Barrel Core

This block is a small in-order processor core that runs several hardware threads on one shared datapath. Every clock cycle the issue slot moves to the next thread in a fixed circular order, so each thread sends exactly one instruction into the pipeline every `NTHREADS` cycles. Each thread keeps its own program counter, accumulator, pointer register, stack pointer and carry flag. The ALU, the instruction read port and the data read/write port are shared by all threads.

The pipeline has as many stages as there are threads: fetch, decode/context read, execute/memory, and writeback. A thread's next instruction is fetched only after its previous one has written back, so the core has no hazard detection, no stalls and no forwarding paths. A thread whose enable input is low keeps its slot in the rotation, but that slot carries an empty bubble, so the cadence of the other threads never changes. Per-thread state is visible on flattened debug outputs; thread `k` occupies bits `[k*W +: W]` of each debug bus.

Top module: `barrel_core`

## Requirements
- R1: After reset, `issue_thread` is 0 in the first cycle and then counts 0,1,2,3,0,... advancing by one on every clock cycle, whatever the enables or the programs do.
- R2: In a cycle where the slot's thread is enabled, `imem_en` is high and `imem_addr` is that thread's program counter; when it is disabled, `imem_en` is low, no memory access and no state change results from that slot, and the thread's program counter keeps its value.
- R3: While reset is low, thread k holds PC = 0x40*k, SP = 0x40*k + 0x3F, and accumulator, pointer and carry all zero.
- R4: An instruction fetched in cycle t retires in cycle t+3 (`retire_valid` high, `retire_thread` equal to the thread fetched at t); with all threads enabled each thread retires exactly once every 4 cycles.
- R5: Instructions are 12 bits: opcode in bits 11:8, immediate in bits 7:0. Opcode 0x1 loads the immediate into the accumulator (carry unchanged); 0x2 adds immediate plus carry to the accumulator, storing bit 8 of the sum in carry.
- R6: Opcode 0x3 loads the immediate into the pointer register; 0x4 loads the accumulator from data memory at the pointer; 0x5 stores the accumulator there. The data access is issued in the execute cycle, and read data is taken in the following cycle.
- R7: Opcode 0x6 writes the accumulator to data memory at SP and then decrements SP; opcode 0x7 increments SP and loads the accumulator from the new SP.
- R8: Opcode 0x8 sets the PC to the immediate when carry is 1, else to PC+1; opcode 0x9 always sets the PC to the immediate; every other instruction advances the PC by one.
- R9: Opcode 0x0 and the unused opcodes 0xA to 0xF change only the PC; a thread spinning in an endless jump loop does not alter the timing or results of any other thread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thread_en | input | NTHREADS | Per-thread run enable, sampled in the fetch slot |
| imem_en | output | 1 | Instruction read strobe |
| imem_addr | output | 8 | Instruction address |
| imem_rdata | input | 12 | Instruction word, valid the cycle after the strobe |
| dmem_addr | output | 8 | Data address |
| dmem_we | output | 1 | Data write strobe |
| dmem_re | output | 1 | Data read strobe |
| dmem_wdata | output | 8 | Write data |
| dmem_rdata | input | 8 | Read data, valid the cycle after the read strobe |
| issue_valid | output | 1 | Current fetch slot carries an instruction |
| issue_thread | output | 2 | Thread owning the current fetch slot |
| retire_valid | output | 1 | An instruction writes back this cycle |
| retire_thread | output | 2 | Thread writing back this cycle |
| dbg_pc | output | NTHREADS*8 | Program counters, thread k at [8k +: 8] |
| dbg_acc | output | NTHREADS*8 | Accumulators |
| dbg_ptr | output | NTHREADS*8 | Pointer registers |
| dbg_sp | output | NTHREADS*8 | Stack pointers |
| dbg_carry | output | NTHREADS | Carry flags |

## Verification
The assertions assume that both memories answer with exactly one cycle of read latency and that `thread_en` is only meaningful at the fetch slot; the bench's memory models register the addressed word on the clock edge after each strobe, matching that. The latency check is armed only once three clocks have passed since reset, because the fetch slot may carry a valid bit while the pipeline registers are still held in reset. The bench changes `thread_en` only while reset is held, so every in-flight instruction belongs to a consistent enable pattern and the frozen-state property for idle threads sees no partial writeback.

// File: rtl/barrel_pkg.sv
package barrel_pkg;

  localparam int unsigned DATA_W  = 8;
  localparam int unsigned ADDR_W  = 8;
  localparam int unsigned OP_W    = 4;
  localparam int unsigned INSTR_W = OP_W + DATA_W;

  typedef enum logic [OP_W-1:0] {
    OP_NOP  = 4'h0,
    OP_LDI  = 4'h1,
    OP_ADC  = 4'h2,
    OP_LDP  = 4'h3,
    OP_LD   = 4'h4,
    OP_ST   = 4'h5,
    OP_PUSH = 4'h6,
    OP_POP  = 4'h7,
    OP_BC   = 4'h8,
    OP_JMP  = 4'h9
  } opcode_e;

  // Architectural state held once per thread
  typedef struct packed {
    logic [ADDR_W-1:0] pc;
    logic [DATA_W-1:0] acc;
    logic [ADDR_W-1:0] ptr;
    logic [ADDR_W-1:0] sp;
    logic              carry;
  } ctx_t;

  // Sum with carry-out in the top bit
  function automatic logic [DATA_W:0] add_carry(input logic [DATA_W-1:0] a,
                                                input logic [DATA_W-1:0] b,
                                                input logic              cin);
    return {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
  endfunction

  // Program counter after a branch decision
  function automatic logic [ADDR_W-1:0] pick_pc(input logic [ADDR_W-1:0] pc,
                                               input logic [ADDR_W-1:0] target,
                                               input logic              take);
    return take ? target : pc + 1'b1;
  endfunction

endpackage

// File: rtl/barrel_rotor.sv
module barrel_rotor #(
  parameter int unsigned N     = 4,
  parameter int unsigned TID_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [TID_W-1:0] slot
);
  localparam logic [TID_W-1:0] LAST = TID_W'(N - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            slot <= '0;
    else if (slot == LAST) slot <= '0;
    else                   slot <= slot + 1'b1;
  end
endmodule

// File: rtl/barrel_ctx.sv
module barrel_ctx
  import barrel_pkg::*;
#(
  parameter int unsigned N     = 4,
  parameter int unsigned TID_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [TID_W-1:0] wid,
  input  ctx_t             wdata,
  output ctx_t             state [N]
);
  localparam int unsigned REGION = (1 << ADDR_W) / N;

  for (genvar k = 0; k < N; k++) begin : g_thread
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        state[k] <= '{pc:    ADDR_W'(k * REGION),
                      acc:   '0,
                      ptr:   '0,
                      sp:    ADDR_W'((k + 1) * REGION - 1),
                      carry: 1'b0};
      end else if (we && wid == TID_W'(k)) begin
        state[k] <= wdata;
      end
    end
  end
endmodule

// File: rtl/barrel_exec.sv
module barrel_exec
  import barrel_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  input  ctx_t               cur,
  output ctx_t               nxt,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic               mem_rd,
  output logic               mem_wr,
  output logic [DATA_W-1:0]  mem_wdata,
  output logic               load_acc
);
  opcode_e           op;
  logic [DATA_W-1:0] imm;
  logic [DATA_W:0]   sum;

  assign op  = opcode_e'(instr[INSTR_W-1 -: OP_W]);
  assign imm = instr[DATA_W-1:0];
  assign sum = add_carry(cur.acc, imm, cur.carry);

  always_comb begin
    nxt       = cur;
    nxt.pc    = pick_pc(cur.pc, imm, 1'b0);
    mem_addr  = '0;
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    mem_wdata = cur.acc;
    load_acc  = 1'b0;
    case (op)
      OP_LDI: nxt.acc = imm;
      OP_ADC: {nxt.carry, nxt.acc} = sum;
      OP_LDP: nxt.ptr = imm;
      OP_LD: begin
        mem_addr = cur.ptr;
        mem_rd   = 1'b1;
        load_acc = 1'b1;
      end
      OP_ST: begin
        mem_addr = cur.ptr;
        mem_wr   = 1'b1;
      end
      OP_PUSH: begin
        mem_addr = cur.sp;
        mem_wr   = 1'b1;
        nxt.sp   = cur.sp - 1'b1;
      end
      OP_POP: begin
        mem_addr = cur.sp + 1'b1;
        mem_rd   = 1'b1;
        load_acc = 1'b1;
        nxt.sp   = cur.sp + 1'b1;
      end
      OP_BC:   nxt.pc = pick_pc(cur.pc, imm, cur.carry);
      OP_JMP:  nxt.pc = pick_pc(cur.pc, imm, 1'b1);
      default: ;
    endcase
  end
endmodule

// File: rtl/barrel_core.sv
module barrel_core
  import barrel_pkg::*;
#(
  parameter  int unsigned NTHREADS = 4,
  localparam int unsigned TID_W    = $clog2(NTHREADS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NTHREADS-1:0]          thread_en,
  output logic                         imem_en,
  output logic [ADDR_W-1:0]            imem_addr,
  input  logic [INSTR_W-1:0]           imem_rdata,
  output logic [ADDR_W-1:0]            dmem_addr,
  output logic                         dmem_we,
  output logic                         dmem_re,
  output logic [DATA_W-1:0]            dmem_wdata,
  input  logic [DATA_W-1:0]            dmem_rdata,
  output logic                         issue_valid,
  output logic [TID_W-1:0]             issue_thread,
  output logic                         retire_valid,
  output logic [TID_W-1:0]             retire_thread,
  output logic [NTHREADS*ADDR_W-1:0]   dbg_pc,
  output logic [NTHREADS*DATA_W-1:0]   dbg_acc,
  output logic [NTHREADS*ADDR_W-1:0]   dbg_ptr,
  output logic [NTHREADS*ADDR_W-1:0]   dbg_sp,
  output logic [NTHREADS-1:0]          dbg_carry
);
  ctx_t               ctx_q [NTHREADS];
  logic [TID_W-1:0]   slot;

  // decode/context-read stage
  logic               d_valid;
  logic [TID_W-1:0]   d_tid;
  // execute stage
  logic               e_valid;
  logic [TID_W-1:0]   e_tid;
  logic [INSTR_W-1:0] e_instr;
  ctx_t               e_ctx;
  // writeback stage
  logic               w_valid;
  logic [TID_W-1:0]   w_tid;
  ctx_t               w_ctx;
  logic               w_load;

  ctx_t               x_nxt;
  logic [ADDR_W-1:0]  x_addr;
  logic               x_rd;
  logic               x_wr;
  logic [DATA_W-1:0]  x_wdata;
  logic               x_load;
  ctx_t               wb_ctx;

  barrel_rotor #(.N(NTHREADS), .TID_W(TID_W)) u_rotor (
    .clk   (clk),
    .rst_n (rst_n),
    .slot  (slot)
  );

  // Fetch: the slot owner reads its PC; a disabled owner leaves a bubble
  assign issue_thread = slot;
  assign issue_valid  = thread_en[slot];
  assign imem_en      = issue_valid;
  assign imem_addr    = ctx_q[slot].pc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_valid <= 1'b0;
      d_tid   <= '0;
      e_valid <= 1'b0;
      e_tid   <= '0;
      e_instr <= '0;
      e_ctx   <= '0;
      w_valid <= 1'b0;
      w_tid   <= '0;
      w_ctx   <= '0;
      w_load  <= 1'b0;
    end else begin
      d_valid <= issue_valid;
      d_tid   <= slot;
      e_valid <= d_valid;
      e_tid   <= d_tid;
      e_instr <= imem_rdata;
      e_ctx   <= ctx_q[d_tid];
      w_valid <= e_valid;
      w_tid   <= e_tid;
      w_ctx   <= x_nxt;
      w_load  <= e_valid & x_load;
    end
  end

  barrel_exec u_exec (
    .instr     (e_instr),
    .cur       (e_ctx),
    .nxt       (x_nxt),
    .mem_addr  (x_addr),
    .mem_rd    (x_rd),
    .mem_wr    (x_wr),
    .mem_wdata (x_wdata),
    .load_acc  (x_load)
  );

  assign dmem_addr  = x_addr;
  assign dmem_we    = e_valid & x_wr;
  assign dmem_re    = e_valid & x_rd;
  assign dmem_wdata = x_wdata;

  // Writeback: merge load data into the context computed in execute
  always_comb begin
    wb_ctx = w_ctx;
    if (w_load) wb_ctx.acc = dmem_rdata;
  end

  assign retire_valid  = w_valid;
  assign retire_thread = w_tid;

  barrel_ctx #(.N(NTHREADS), .TID_W(TID_W)) u_ctx (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (w_valid),
    .wid   (w_tid),
    .wdata (wb_ctx),
    .state (ctx_q)
  );

  for (genvar k = 0; k < NTHREADS; k++) begin : g_dbg
    assign dbg_pc [k*ADDR_W +: ADDR_W] = ctx_q[k].pc;
    assign dbg_acc[k*DATA_W +: DATA_W] = ctx_q[k].acc;
    assign dbg_ptr[k*ADDR_W +: ADDR_W] = ctx_q[k].ptr;
    assign dbg_sp [k*ADDR_W +: ADDR_W] = ctx_q[k].sp;
    assign dbg_carry[k]                = ctx_q[k].carry;
  end
endmodule

// File: rtl/barrel_core_chk.sv
module barrel_core_chk
  import barrel_pkg::*;
#(
  parameter int unsigned N     = 4,
  parameter int unsigned TID_W = $clog2(N)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [N-1:0]         thread_en,
  input logic                 imem_en,
  input logic                 dmem_we,
  input logic                 dmem_re,
  input logic                 issue_valid,
  input logic [TID_W-1:0]     issue_thread,
  input logic                 retire_valid,
  input logic [TID_W-1:0]     retire_thread,
  input logic [N*ADDR_W-1:0]  dbg_pc,
  input logic [N*DATA_W-1:0]  dbg_acc,
  input logic [N*ADDR_W-1:0]  dbg_ptr,
  input logic [N*ADDR_W-1:0]  dbg_sp,
  input logic [N-1:0]         dbg_carry
);
  localparam logic [TID_W-1:0] LAST = TID_W'(N - 1);

  logic [1:0]       since_rst;
  logic             warm;
  logic [TID_W-1:0] after_issue;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since_rst <= '0;
    else if (since_rst != 3) since_rst <= since_rst + 1'b1;
  end
  assign warm        = (since_rst == 2'd3);
  assign after_issue = (issue_thread == LAST) ? '0 : issue_thread + 1'b1;

  // R1: slot owner advances by one every cycle with wrap
  p_rotate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> issue_thread == (($past(issue_thread) == LAST) ? '0 : $past(issue_thread) + 1'b1));

  // R2: no fetch for a disabled slot owner
  p_fetch_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    imem_en |-> thread_en[issue_thread] && issue_valid);

  // R4: fetch-to-retire latency of three cycles
  p_retire_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> retire_valid == $past(issue_valid, 3));

  // R4: retiring thread trails the fetch slot by N-1 positions
  p_retire_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    retire_valid |-> retire_thread == after_issue);

  // R6: one data access per cycle
  p_dmem_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(dmem_we && dmem_re));

  // R9: a thread's state moves only when that thread retires
  for (genvar k = 0; k < N; k++) begin : g_frozen
    p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(retire_valid && retire_thread == TID_W'(k)) |=>
        $stable(dbg_pc[k*ADDR_W +: ADDR_W]) && $stable(dbg_acc[k*DATA_W +: DATA_W]) &&
        $stable(dbg_ptr[k*ADDR_W +: ADDR_W]) && $stable(dbg_sp[k*ADDR_W +: ADDR_W]) &&
        $stable(dbg_carry[k]));
  end
endmodule

bind barrel_core barrel_core_chk #(.N(NTHREADS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .thread_en     (thread_en),
  .imem_en       (imem_en),
  .dmem_we       (dmem_we),
  .dmem_re       (dmem_re),
  .issue_valid   (issue_valid),
  .issue_thread  (issue_thread),
  .retire_valid  (retire_valid),
  .retire_thread (retire_thread),
  .dbg_pc        (dbg_pc),
  .dbg_acc       (dbg_acc),
  .dbg_ptr       (dbg_ptr),
  .dbg_sp        (dbg_sp),
  .dbg_carry     (dbg_carry)
);

// File: tb/barrel_core_tb_top.sv
module barrel_core_tb_top;
  localparam int NT = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  thread_en = 4'h0;
  logic        imem_en;
  logic [7:0]  imem_addr;
  logic [11:0] imem_rdata = '0;
  logic [7:0]  dmem_addr;
  logic        dmem_we, dmem_re;
  logic [7:0]  dmem_wdata;
  logic [7:0]  dmem_rdata = '0;
  logic        issue_valid, retire_valid;
  logic [1:0]  issue_thread, retire_thread;
  logic [31:0] dbg_pc, dbg_acc, dbg_ptr, dbg_sp;
  logic [3:0]  dbg_carry;

  logic [11:0] imem [256];
  logic [7:0]  dmem [256];
  logic        clr_dmem = 1'b0;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  barrel_core dut_i (
    .clk(clk), .rst_n(rst_n), .thread_en(thread_en),
    .imem_en(imem_en), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_we(dmem_we), .dmem_re(dmem_re),
    .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
    .issue_valid(issue_valid), .issue_thread(issue_thread),
    .retire_valid(retire_valid), .retire_thread(retire_thread),
    .dbg_pc(dbg_pc), .dbg_acc(dbg_acc), .dbg_ptr(dbg_ptr),
    .dbg_sp(dbg_sp), .dbg_carry(dbg_carry)
  );

  // One-cycle synchronous memories
  always @(posedge clk) begin
    if (imem_en) imem_rdata <= imem[imem_addr];
    if (clr_dmem) begin
      for (int i = 0; i < 256; i++) dmem[i] <= 8'h00;
    end else begin
      if (dmem_we) dmem[dmem_addr] <= dmem_wdata;
      if (dmem_re) dmem_rdata <= dmem[dmem_addr];
    end
  end

  function automatic logic [11:0] ins(input logic [3:0] op, input logic [7:0] imm);
    return {op, imm};
  endfunction

  function automatic logic [7:0] pc_of(input int k);  return dbg_pc [k*8 +: 8]; endfunction
  function automatic logic [7:0] acc_of(input int k); return dbg_acc[k*8 +: 8]; endfunction
  function automatic logic [7:0] ptr_of(input int k); return dbg_ptr[k*8 +: 8]; endfunction
  function automatic logic [7:0] sp_of(input int k);  return dbg_sp [k*8 +: 8]; endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_imem();
    for (int i = 0; i < 256; i++) imem[i] = 12'h000;
  endtask

  task automatic hold_reset(input logic [3:0] en);
    @(negedge clk);
    rst_n = 1'b0;
    thread_en = en;
    clr_dmem = 1'b1;
    @(posedge clk);
    @(posedge clk);
    clr_dmem = 1'b0;
    @(negedge clk);
  endtask

  task automatic release_reset();
    rst_n = 1'b1;
  endtask

  // Four threads, one scenario each
  task automatic load_main();
    clear_imem();
    // thread 0: unused opcode, then endless self-jump
    imem[8'h00] = ins(4'hF, 8'h5A);
    imem[8'h01] = ins(4'h9, 8'h01);
    // thread 1: carry branch taken, then not taken
    imem[8'h40] = ins(4'h1, 8'hFF);
    imem[8'h41] = ins(4'h2, 8'h01);
    imem[8'h42] = ins(4'h8, 8'h50);
    imem[8'h43] = ins(4'h1, 8'h77);
    imem[8'h44] = ins(4'h9, 8'h44);
    imem[8'h50] = ins(4'h1, 8'h33);
    imem[8'h51] = ins(4'h2, 8'h00);
    imem[8'h52] = ins(4'h8, 8'h60);
    imem[8'h53] = ins(4'h2, 8'h01);
    imem[8'h54] = ins(4'h9, 8'h54);
    imem[8'h60] = ins(4'h1, 8'hEE);
    imem[8'h61] = ins(4'h9, 8'h61);
    // thread 2: store and load through the pointer
    imem[8'h80] = ins(4'h3, 8'h20);
    imem[8'h81] = ins(4'h1, 8'h5A);
    imem[8'h82] = ins(4'h5, 8'h00);
    imem[8'h83] = ins(4'h1, 8'h00);
    imem[8'h84] = ins(4'h4, 8'h00);
    imem[8'h85] = ins(4'h9, 8'h85);
    // thread 3: two pushes and one pop
    imem[8'hC0] = ins(4'h1, 8'h11);
    imem[8'hC1] = ins(4'h6, 8'h00);
    imem[8'hC2] = ins(4'h1, 8'h22);
    imem[8'hC3] = ins(4'h6, 8'h00);
    imem[8'hC4] = ins(4'h1, 8'h00);
    imem[8'hC5] = ins(4'h7, 8'h00);
    imem[8'hC6] = ins(4'h9, 8'hC6);
  endtask

  // ADC vectors: {a, b, carry_in}
  localparam logic [16:0] ADC_VEC [8] = '{
    {8'h12, 8'h34, 1'b0}, {8'hFF, 8'h01, 1'b0}, {8'hFF, 8'h00, 1'b1},
    {8'h80, 8'h80, 1'b0}, {8'h7F, 8'h7F, 1'b1}, {8'h00, 8'h00, 1'b0},
    {8'hA5, 8'h5A, 1'b1}, {8'h01, 8'hFE, 1'b0}
  };

  initial begin : watchdog
    #(4 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    int cnt [NT];
    int slot2_fetch;

    // R5: table of add-with-carry cases on thread 0
    for (int v = 0; v < 8; v++) begin
      logic [7:0] a, b;
      logic       ci;
      logic [8:0] s;
      {a, b, ci} = ADC_VEC[v];
      s = {1'b0, a} + {1'b0, b} + {8'h00, ci};
      clear_imem();
      imem[8'h00] = ins(4'h1, ci ? 8'hFF : 8'h00);
      imem[8'h01] = ins(4'h2, ci ? 8'h01 : 8'h00);
      imem[8'h02] = ins(4'h1, a);
      imem[8'h03] = ins(4'h2, b);
      imem[8'h04] = ins(4'h9, 8'h04);
      hold_reset(4'b0001);
      release_reset();
      repeat (40) @(negedge clk);
      check("R5 adc sum", {8'h00, acc_of(0)}, {8'h00, s[7:0]});
      check("R5 adc carry", {15'h0, dbg_carry[0]}, {15'h0, s[8]});
    end

    // R3: state while reset is held
    load_main();
    hold_reset(4'b1111);
    for (int k = 0; k < NT; k++) begin
      check("R3 reset pc", {8'h00, pc_of(k)}, 16'(k * 8'h40));
      check("R3 reset sp", {8'h00, sp_of(k)}, 16'(k * 8'h40 + 8'h3F));
      check("R3 reset acc/ptr/carry", {acc_of(k), ptr_of(k)} | {15'h0, dbg_carry[k]}, 16'h0000);
    end
    release_reset();

    // R1: rotation starts at 0 and steps every cycle; R2 fetch with PC
    for (int i = 0; i < 8; i++) begin
      check("R1 rotation", {14'h0, issue_thread}, 16'(i % 4));
      check("R2 fetch strobe", {15'h0, imem_en}, 16'h0001);
      if (i < 4) check("R2 fetch address", {8'h00, imem_addr}, 16'(i * 8'h40));
      @(negedge clk);
    end

    // R4: retire cadence with all threads enabled
    for (int k = 0; k < NT; k++) cnt[k] = 0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 80; i++) begin
      if (retire_valid) cnt[retire_thread]++;
      @(negedge clk);
    end
    for (int k = 0; k < NT; k++) check("R4 retire count", 16'(cnt[k]), 16'd20);
    repeat (20) @(negedge clk);

    // R9: unused opcode and endless loop in thread 0
    check("R9 nop acc", {8'h00, acc_of(0)}, 16'h0000);
    check("R9 loop pc", {8'h00, pc_of(0)}, 16'h0001);
    // R8: branches in thread 1
    check("R8 branch acc", {8'h00, acc_of(1)}, 16'h0035);
    check("R8 branch pc", {8'h00, pc_of(1)}, 16'h0054);
    check("R8 carry", {15'h0, dbg_carry[1]}, 16'h0000);
    // R6: pointer load/store in thread 2
    check("R6 store", {8'h00, dmem[8'h20]}, 16'h005A);
    check("R6 load acc", {8'h00, acc_of(2)}, 16'h005A);
    check("R6 ptr", {8'h00, ptr_of(2)}, 16'h0020);
    // R7: stack in thread 3
    check("R7 push first", {8'h00, dmem[8'hFF]}, 16'h0011);
    check("R7 push second", {8'h00, dmem[8'hFE]}, 16'h0022);
    check("R7 pop acc", {8'h00, acc_of(3)}, 16'h0022);
    check("R7 sp", {8'h00, sp_of(3)}, 16'h00FE);

    // R2: thread 2 disabled, others unaffected
    hold_reset(4'b1011);
    release_reset();
    for (int k = 0; k < NT; k++) cnt[k] = 0;
    slot2_fetch = 0;
    for (int i = 0; i < 100; i++) begin
      if (imem_en && issue_thread == 2'd2) slot2_fetch++;
      if (retire_valid) cnt[retire_thread]++;
      @(negedge clk);
    end
    check("R2 no fetch when disabled", 16'(slot2_fetch), 16'd0);
    check("R2 no retire when disabled", 16'(cnt[2]), 16'd0);
    check("R2 pc held", {8'h00, pc_of(2)}, 16'h0080);
    check("R2 acc held", {8'h00, acc_of(2)}, 16'h0000);
    check("R2 no store", {8'h00, dmem[8'h20]}, 16'h0000);
    check("R9 neighbour result", {8'h00, acc_of(1)}, 16'h0035);
    check("R9 neighbour stack", {8'h00, acc_of(3)}, 16'h0022);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule